// File: doc/BRIEF.md
# Transactional Line Tracker with Two-Phase Commit

This block keeps the tag and tracking state of a small direct-mapped cache that buffers the writes of one hardware transaction until commit. Every line holds a valid flag, a tag, a read-tracking bit and a write-tracking bit. While a transaction is running, the first read of a line sets its read bit and the first write sets its write bit. Lines with the write bit set hold speculative data that stays local. A miss that would replace a tracked line is refused and reported as a capacity overflow.

A commit runs in two phases. In the first phase the sequencer scans the lines in ascending index order. For every written line it requests exclusive ownership of that block and waits for a grant. When every written line has been granted, a single commit cycle clears all tracking bits at once. The written lines stay valid, which makes their data globally visible. A denied request fails validation. Block addresses committed by other cores arrive on a snoop port. A snoop that hits a tracked line reports a conflict and aborts the local transaction. An abort invalidates every written line and clears all tracking bits in one cycle.

Top module: `txn_track_cache`

## Requirements
- R1: After reset, the valid, read-tracking and write-tracking masks are all zero, and every status output is low.
- R2: The line index is the low log2(LINES) address bits and the tag is the remaining high bits. In the idle state, an access with `tx_active_i` high sets the read bit (`acc_we_i`=0) or the write bit (`acc_we_i`=1) of its line, filling the line on a miss. An access with `tx_active_i` low fills the line without setting either bit.
- R3: An idle-state miss whose target line is valid and has a tracking bit set leaves all line state unchanged. It raises `overflow_o` for exactly one cycle, in the cycle after the access. A miss on a valid untracked line replaces that line.
- R4: A snoop, in the idle or validate state, whose address matches a valid line with a tracking bit set raises `conflict_o` for one cycle in the following cycle. In that same cycle `abort_o` is high. One cycle later every line whose write bit was set is invalid and all tracking bits are zero. A snoop that misses, or that hits an untracked line, changes nothing.
- R5: After `commit_req_i`, the sequencer visits the lines in ascending index order, starting the next cycle. An unwritten line takes one cycle. A written line holds `own_req_o` high, with `own_addr_o` = {tag, index}, until `own_gnt_i` is seen.
- R6: `own_nack_i` while `own_req_o` is high fails validation. `val_fail_o` pulses for one cycle together with `abort_o`, followed by the abort clearing described in R4.
- R7: After the last line is scanned, one cycle clears every tracking bit while keeping all lines valid. Then `commit_done_o` is high for exactly one cycle and the block returns to idle.
- R8: A snoop conflict or an `abort_req_i` in the same idle cycle as an access drops the access. Accesses while `busy_o` is high are ignored.
- R9: `abort_req_i` in the idle state aborts the transaction exactly as a conflict does, without raising `conflict_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_active_i | input | 1 | Accesses are transactional |
| acc_valid_i | input | 1 | Local access strobe |
| acc_we_i | input | 1 | Access is a write |
| acc_addr_i | input | ADDR_W | Access block address |
| snoop_valid_i | input | 1 | Remote commit address strobe |
| snoop_addr_i | input | ADDR_W | Remote committed block address |
| commit_req_i | input | 1 | Start two-phase commit |
| abort_req_i | input | 1 | Software abort request |
| own_gnt_i | input | 1 | Exclusive ownership granted |
| own_nack_i | input | 1 | Exclusive ownership denied |
| own_req_o | output | 1 | Ownership request for a written line |
| own_addr_o | output | ADDR_W | Block address of the request |
| conflict_o | output | 1 | Snoop conflict pulse |
| val_fail_o | output | 1 | Validation failure pulse |
| abort_o | output | 1 | Abort gang-clear cycle |
| commit_done_o | output | 1 | Commit completed pulse |
| overflow_o | output | 1 | Tracked-line eviction refused |
| busy_o | output | 1 | Sequencer not idle |
| vld_mask_o | output | LINES | Valid bit per line |
| rd_mask_o | output | LINES | Read-tracking bit per line |
| wr_mask_o | output | LINES | Write-tracking bit per line |

## Verification
A snoop that hits a tracked line can arrive in the same idle cycle as a local access. The bench drives a write to a fresh index together with a conflicting snoop and expects the abort to win: the fresh index must stay invalid. The same pairing is repeated with a software abort. A snoop is also delivered while validation is stalled on an ungranted ownership request, so that the conflict and the scan overlap. A behavioural model compares every output on every cycle.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
    typedef enum logic [2:0] {
        SEQ_IDLE     = 3'd0,
        SEQ_VALIDATE = 3'd1,
        SEQ_COMMIT   = 3'd2,
        SEQ_DONE     = 3'd3,
        SEQ_ABORT    = 3'd4
    } seq_state_e;
endpackage

// File: rtl/ttc_lookup.sv
module ttc_lookup #(
    parameter int LINES  = 8,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 5
) (
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [TAG_W-1:0]            tag_i,
    input  logic [LINES-1:0]            vld_i,
    input  logic [LINES-1:0][TAG_W-1:0] tags_i,
    input  logic [LINES-1:0]            rd_i,
    input  logic [LINES-1:0]            wr_i,
    output logic                        hit_o,
    output logic                        tracked_o
);
    always_comb begin
        hit_o     = vld_i[idx_i] && (tags_i[idx_i] == tag_i);
        tracked_o = vld_i[idx_i] && (rd_i[idx_i] || wr_i[idx_i]);
    end
endmodule

// File: rtl/ttc_seq.sv
module ttc_seq
    import ttc_pkg::*;
#(
    parameter int LINES = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_req_i,
    input  logic             abort_req_i,
    input  logic             conflict_i,
    input  logic [LINES-1:0] wr_mask_i,
    input  logic             own_gnt_i,
    input  logic             own_nack_i,
    output seq_state_e       state_o,
    output logic [IDX_W-1:0] scan_idx_o,
    output logic             own_req_o,
    output logic             conflict_o,
    output logic             val_fail_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic             conf;
        logic             vfail;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      conf_eff;

    always_comb begin
        seq_d       = seq_q;
        conf_eff    = conflict_i && (seq_q.st == SEQ_IDLE || seq_q.st == SEQ_VALIDATE);
        seq_d.conf  = conf_eff;
        seq_d.vfail = 1'b0;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (conf_eff || abort_req_i) begin
                    seq_d.st = SEQ_ABORT;
                end else if (commit_req_i) begin
                    seq_d.st  = SEQ_VALIDATE;
                    seq_d.idx = '0;
                end
            end
            SEQ_VALIDATE: begin
                if (conf_eff) begin
                    seq_d.st = SEQ_ABORT;
                end else if (wr_mask_i[seq_q.idx] && own_nack_i) begin
                    seq_d.st    = SEQ_ABORT;
                    seq_d.vfail = 1'b1;
                end else if (!wr_mask_i[seq_q.idx] || own_gnt_i) begin
                    if (seq_q.idx == LAST_IDX) seq_d.st = SEQ_COMMIT;
                    else                        seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            SEQ_COMMIT: seq_d.st = SEQ_DONE;
            SEQ_DONE:   seq_d.st = SEQ_IDLE;
            SEQ_ABORT:  seq_d.st = SEQ_IDLE;
            default:    seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, idx: '0, conf: 1'b0, vfail: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o    = seq_q.st;
    assign scan_idx_o = seq_q.idx;
    assign own_req_o  = (seq_q.st == SEQ_VALIDATE) && wr_mask_i[seq_q.idx];
    assign conflict_o = seq_q.conf;
    assign val_fail_o = seq_q.vfail;

    // R5: an ungranted ownership request stays up on the same line
    assert_own_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (own_req_o && !own_gnt_i && !own_nack_i && !conflict_i) |=> (own_req_o && $stable(scan_idx_o)));
    // R6: a denied request fails validation and aborts
    assert_nack_aborts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (own_req_o && own_nack_i && !conflict_i) |=> (val_fail_o && state_o == SEQ_ABORT));
    // R7: completion is a single cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == SEQ_DONE) |=> (state_o == SEQ_IDLE));
    // R4: a reported conflict coincides with the abort cycle
    assert_conflict_aborts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_o |-> (state_o == SEQ_ABORT));
endmodule

// File: rtl/txn_track_cache.sv
module txn_track_cache
    import ttc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LINES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_active_i,
    input  logic              acc_valid_i,
    input  logic              acc_we_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              snoop_valid_i,
    input  logic [ADDR_W-1:0] snoop_addr_i,
    input  logic              commit_req_i,
    input  logic              abort_req_i,
    input  logic              own_gnt_i,
    input  logic              own_nack_i,
    output logic              own_req_o,
    output logic [ADDR_W-1:0] own_addr_o,
    output logic              conflict_o,
    output logic              val_fail_o,
    output logic              abort_o,
    output logic              commit_done_o,
    output logic              overflow_o,
    output logic              busy_o,
    output logic [LINES-1:0]  vld_mask_o,
    output logic [LINES-1:0]  rd_mask_o,
    output logic [LINES-1:0]  wr_mask_o
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic [LINES-1:0]            vld;
        logic [LINES-1:0]            rd;
        logic [LINES-1:0]            wr;
        logic [LINES-1:0][TAG_W-1:0] tag;
        logic                        ovf;
    } line_regs_t;

    line_regs_t ln_d, ln_q;

    seq_state_e       seq_state;
    logic [IDX_W-1:0] scan_idx;
    logic             acc_hit, acc_trk, snp_hit, snp_trk, snp_conf, acc_take;
    logic [IDX_W-1:0] acc_idx, snp_idx;
    logic [TAG_W-1:0] acc_tag, snp_tag;

    assign acc_idx = acc_addr_i[IDX_W-1:0];
    assign acc_tag = acc_addr_i[ADDR_W-1:IDX_W];
    assign snp_idx = snoop_addr_i[IDX_W-1:0];
    assign snp_tag = snoop_addr_i[ADDR_W-1:IDX_W];

    ttc_lookup #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) acc_lk_i (
        .idx_i(acc_idx), .tag_i(acc_tag), .vld_i(ln_q.vld), .tags_i(ln_q.tag),
        .rd_i(ln_q.rd), .wr_i(ln_q.wr), .hit_o(acc_hit), .tracked_o(acc_trk)
    );

    ttc_lookup #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) snp_lk_i (
        .idx_i(snp_idx), .tag_i(snp_tag), .vld_i(ln_q.vld), .tags_i(ln_q.tag),
        .rd_i(ln_q.rd), .wr_i(ln_q.wr), .hit_o(snp_hit), .tracked_o(snp_trk)
    );

    assign snp_conf = snoop_valid_i && snp_hit && snp_trk;

    ttc_seq #(.LINES(LINES), .IDX_W(IDX_W)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .commit_req_i(commit_req_i), .abort_req_i(abort_req_i),
        .conflict_i(snp_conf), .wr_mask_i(ln_q.wr),
        .own_gnt_i(own_gnt_i), .own_nack_i(own_nack_i),
        .state_o(seq_state), .scan_idx_o(scan_idx), .own_req_o(own_req_o),
        .conflict_o(conflict_o), .val_fail_o(val_fail_o)
    );

    assign acc_take = acc_valid_i && (seq_state == SEQ_IDLE) && !snp_conf && !abort_req_i;

    always_comb begin
        ln_d     = ln_q;
        ln_d.ovf = 1'b0;
        if (seq_state == SEQ_ABORT) begin
            ln_d.vld = ln_q.vld & ~ln_q.wr;
            ln_d.rd  = '0;
            ln_d.wr  = '0;
        end else if (seq_state == SEQ_COMMIT) begin
            ln_d.rd = '0;
            ln_d.wr = '0;
        end else if (acc_take) begin
            if (acc_hit) begin
                if (tx_active_i && acc_we_i)  ln_d.wr[acc_idx] = 1'b1;
                if (tx_active_i && !acc_we_i) ln_d.rd[acc_idx] = 1'b1;
            end else if (acc_trk) begin
                ln_d.ovf = 1'b1;
            end else begin
                ln_d.vld[acc_idx] = 1'b1;
                ln_d.tag[acc_idx] = acc_tag;
                ln_d.rd[acc_idx]  = tx_active_i && !acc_we_i;
                ln_d.wr[acc_idx]  = tx_active_i && acc_we_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign own_addr_o    = {ln_q.tag[scan_idx], scan_idx};
    assign abort_o       = (seq_state == SEQ_ABORT);
    assign commit_done_o = (seq_state == SEQ_DONE);
    assign busy_o        = (seq_state != SEQ_IDLE);
    assign overflow_o    = ln_q.ovf;
    assign vld_mask_o    = ln_q.vld;
    assign rd_mask_o     = ln_q.rd;
    assign wr_mask_o     = ln_q.wr;

    // R4: abort leaves no tracking bit and no written line valid
    assert_abort_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> (rd_mask_o == '0 && wr_mask_o == '0 && (vld_mask_o & $past(wr_mask_o)) == '0));
    // R7: the commit cycle clears tracking and keeps every line valid
    assert_commit_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_COMMIT) |=> (wr_mask_o == '0 && rd_mask_o == '0 && $stable(vld_mask_o)));
    // R3: a refused eviction leaves the lines untouched
    assert_no_overflow_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> ($stable(vld_mask_o) && $stable(rd_mask_o) && $stable(wr_mask_o) && $stable(ln_q.tag)));
    // R8: no line is filled while the sequencer is busy
    assert_busy_no_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(ln_q.tag));
endmodule

// File: tb/txn_track_cache_tb_top.sv
`timescale 1ns/1ps
module txn_track_cache_tb_top;
    localparam int AW = 8;
    localparam int NL = 8;
    localparam int S_IDLE = 0, S_VAL = 1, S_COM = 2, S_DONE = 3, S_ABT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_active_i = 1'b0, acc_valid_i = 1'b0, acc_we_i = 1'b0;
    logic [AW-1:0] acc_addr_i = '0, snoop_addr_i = '0;
    logic snoop_valid_i = 1'b0, commit_req_i = 1'b0, abort_req_i = 1'b0;
    logic own_gnt_i = 1'b0, own_nack_i = 1'b0;
    logic own_req_o, conflict_o, val_fail_o, abort_o, commit_done_o, overflow_o, busy_o;
    logic [AW-1:0] own_addr_o;
    logic [NL-1:0] vld_mask_o, rd_mask_o, wr_mask_o;

    always #2 clk = ~clk;

    txn_track_cache #(.ADDR_W(AW), .LINES(NL)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_active_i(tx_active_i), .acc_valid_i(acc_valid_i),
        .acc_we_i(acc_we_i), .acc_addr_i(acc_addr_i), .snoop_valid_i(snoop_valid_i),
        .snoop_addr_i(snoop_addr_i), .commit_req_i(commit_req_i), .abort_req_i(abort_req_i),
        .own_gnt_i(own_gnt_i), .own_nack_i(own_nack_i), .own_req_o(own_req_o),
        .own_addr_o(own_addr_o), .conflict_o(conflict_o), .val_fail_o(val_fail_o),
        .abort_o(abort_o), .commit_done_o(commit_done_o), .overflow_o(overflow_o),
        .busy_o(busy_o), .vld_mask_o(vld_mask_o), .rd_mask_o(rd_mask_o), .wr_mask_o(wr_mask_o)
    );

    int n_checks = 0, n_errors = 0, cyc = 0;
    bit gnt_en = 0, nack_en = 0, tick = 0, finished = 0;

    // reference model state
    bit [NL-1:0] m_v, m_r, m_w;
    int m_t [NL];
    int m_st = S_IDLE, m_ix = 0;
    bit m_conf, m_vf, m_ovf;
    int si, stg, ai, atg;
    bit conf;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_v = '0; m_r = '0; m_w = '0;
            foreach (m_t[k]) m_t[k] = 0;
            m_st = S_IDLE; m_ix = 0; m_conf = 0; m_vf = 0; m_ovf = 0;
        end else begin
            si = snoop_addr_i % NL; stg = snoop_addr_i / NL;
            ai = acc_addr_i % NL;   atg = acc_addr_i / NL;
            conf = snoop_valid_i && m_v[si] && (m_t[si] == stg) && (m_r[si] || m_w[si])
                   && (m_st == S_IDLE || m_st == S_VAL);
            m_conf = conf; m_vf = 0; m_ovf = 0;
            case (m_st)
                S_IDLE: begin
                    if (conf || abort_req_i) m_st = S_ABT;
                    else begin
                        if (acc_valid_i) begin
                            if (m_v[ai] && m_t[ai] == atg) begin
                                if (tx_active_i && acc_we_i) m_w[ai] = 1;
                                if (tx_active_i && !acc_we_i) m_r[ai] = 1;
                            end else if (m_v[ai] && (m_r[ai] || m_w[ai])) m_ovf = 1;
                            else begin
                                m_v[ai] = 1; m_t[ai] = atg;
                                m_r[ai] = tx_active_i && !acc_we_i;
                                m_w[ai] = tx_active_i && acc_we_i;
                            end
                        end
                        if (commit_req_i) begin m_st = S_VAL; m_ix = 0; end
                    end
                end
                S_VAL: begin
                    if (conf) m_st = S_ABT;
                    else if (m_w[m_ix] && own_nack_i) begin m_st = S_ABT; m_vf = 1; end
                    else if (!m_w[m_ix] || own_gnt_i) begin
                        if (m_ix == NL - 1) m_st = S_COM; else m_ix++;
                    end
                end
                S_COM: begin m_r = '0; m_w = '0; m_st = S_DONE; end
                S_DONE: m_st = S_IDLE;
                default: begin m_v = m_v & ~m_w; m_r = '0; m_w = '0; m_st = S_IDLE; end
            endcase
        end
    end

    // grant/deny responder, updated away from the active edge
    always @(negedge clk) begin
        tick <= ~tick;
        own_gnt_i  <= rst_n && gnt_en && own_req_o && tick;
        own_nack_i <= rst_n && nack_en && own_req_o;
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(vld_mask_o == m_v, "R2 vld", vld_mask_o, m_v);
            chk(rd_mask_o == m_r, "R2 rd", rd_mask_o, m_r);
            chk(wr_mask_o == m_w, "R2 wr", wr_mask_o, m_w);
            chk(overflow_o == m_ovf, "R3 overflow", overflow_o, m_ovf);
            chk(conflict_o == m_conf, "R4 conflict", conflict_o, m_conf);
            chk(abort_o == (m_st == S_ABT), "R4 abort", abort_o, m_st == S_ABT);
            chk(own_req_o == (m_st == S_VAL && m_w[m_ix]), "R5 own_req", own_req_o, m_st == S_VAL && m_w[m_ix]);
            if (own_req_o)
                chk(own_addr_o == AW'(m_t[m_ix] * NL + m_ix), "R5 own_addr", own_addr_o, m_t[m_ix] * NL + m_ix);
            chk(val_fail_o == m_vf, "R6 val_fail", val_fail_o, m_vf);
            chk(commit_done_o == (m_st == S_DONE), "R7 done", commit_done_o, m_st == S_DONE);
            chk(busy_o == (m_st != S_IDLE), "R8 busy", busy_o, m_st != S_IDLE);
        end
    end

    task automatic step(); @(posedge clk); #1; endtask

    task automatic acc(input bit we, input int addr, input bit tx);
        acc_valid_i = 1; acc_we_i = we; acc_addr_i = AW'(addr); tx_active_i = tx;
        step();
        acc_valid_i = 0; acc_we_i = 0;
    endtask

    task automatic snoop(input int addr);
        snoop_valid_i = 1; snoop_addr_i = AW'(addr);
        step();
        snoop_valid_i = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60 && busy_o; i++) step();
    endtask

    task automatic do_commit();
        commit_req_i = 1; step(); commit_req_i = 0;
        wait_idle();
    endtask

    task automatic summary();
        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1; step();
        chk(vld_mask_o == 0 && rd_mask_o == 0 && wr_mask_o == 0, "R1 masks", vld_mask_o, 0);
        chk(!busy_o && !overflow_o && !conflict_o && !own_req_o, "R1 status", busy_o, 0);

        // R2 tracking and non-transactional fill
        acc(0, 8'h01, 1); acc(1, 8'h0A, 1); acc(0, 8'h03, 1); acc(1, 8'h03, 1); acc(1, 8'h1D, 0);
        step();
        chk(rd_mask_o == 8'h0A && wr_mask_o == 8'h0C, "R2 bits", {rd_mask_o, wr_mask_o}, 16'h0A0C);
        chk(vld_mask_o == 8'h2E, "R2 fill", vld_mask_o, 8'h2E);

        // R3 refused eviction, then replacement of untracked line
        acc(0, 8'h11, 1);
        chk(overflow_o == 1, "R3 pulse", overflow_o, 1);
        step();
        chk(overflow_o == 0, "R3 one cycle", overflow_o, 0);
        acc(0, 8'h25, 1);
        chk(overflow_o == 0 && rd_mask_o[5], "R3 replace", rd_mask_o, 8'h2A);

        // R5/R7 commit with delayed grants
        gnt_en = 1;
        do_commit();
        chk(wr_mask_o == 0 && rd_mask_o == 0 && vld_mask_o == 8'h2E, "R7 kept", vld_mask_o, 8'h2E);

        // R4 snoop miss, then conflict
        acc(1, 8'h02, 1); acc(0, 8'h01, 1);
        snoop(8'h0A); step();
        chk(!abort_o && wr_mask_o[2], "R4 miss ignored", wr_mask_o, 8'h04);
        snoop(8'h01);
        chk(conflict_o && abort_o, "R4 conflict", conflict_o, 1);
        step();
        chk(!vld_mask_o[2] && vld_mask_o[1] && rd_mask_o == 0, "R4 cleared", vld_mask_o, 8'h2A);

        // R8 snoop conflict and access in the same cycle
        acc(1, 8'h04, 1);
        acc_valid_i = 1; acc_we_i = 1; acc_addr_i = 8'h06; snoop_valid_i = 1; snoop_addr_i = 8'h04;
        step();
        acc_valid_i = 0; snoop_valid_i = 0;
        wait_idle();
        chk(!vld_mask_o[6] && !vld_mask_o[4], "R8 access dropped", vld_mask_o, 8'h2A);

        // R6 denied ownership
        acc(1, 8'h07, 1);
        gnt_en = 0; nack_en = 1;
        commit_req_i = 1; step(); commit_req_i = 0;
        for (int i = 0; i < 20 && !val_fail_o; i++) step();
        chk(val_fail_o && abort_o, "R6 fail", val_fail_o, 1);
        wait_idle();
        chk(!vld_mask_o[7], "R6 discarded", vld_mask_o, 8'h2A);
        nack_en = 0;

        // R4/R5 conflict during a stalled validation
        acc(0, 8'h01, 1); acc(1, 8'h03, 1);
        commit_req_i = 1; step(); commit_req_i = 0;
        repeat (6) step();
        chk(own_req_o && own_addr_o == 8'h03, "R5 stalled", own_addr_o, 8'h03);
        snoop(8'h01);
        chk(conflict_o && abort_o, "R4 in validate", conflict_o, 1);
        wait_idle();
        chk(!vld_mask_o[3], "R4 written dropped", vld_mask_o, 8'h22);

        // R9 software abort with a same-cycle access
        acc(1, 8'h05, 1);
        abort_req_i = 1; acc_valid_i = 1; acc_we_i = 0; acc_addr_i = 8'h06;
        step();
        abort_req_i = 0; acc_valid_i = 0;
        chk(abort_o && !conflict_o, "R9 abort", abort_o, 1);
        wait_idle();
        chk(!vld_mask_o[5] && !vld_mask_o[6], "R9 cleared", vld_mask_o, 8'h02);

        // R8 access while busy is ignored
        acc(1, 8'h00, 1);
        gnt_en = 1;
        commit_req_i = 1; step(); commit_req_i = 0;
        acc(1, 8'h07, 1);
        wait_idle();
        chk(!vld_mask_o[7] && vld_mask_o[0], "R8 busy ignore", vld_mask_o, 8'h03);

        repeat (3) step();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            summary();
        end
    end
endmodule